// File: doc/BRIEF.md
# Mode-configurable DSP processing element

This block is a fixed datapath built from four pipelined multipliers and seven pipelined adder-subtractors. A small multiplexer network between the unit ranks reroutes them according to a 3-bit mode code. One shared pool of hardware can therefore compute a single add, subtract or multiply, a radix-2 complex butterfly, a 2-tap FIR, a 4-tap FIR, or a 4-tap FIR with an unrelated addition running beside it. Arithmetic is 16-bit two's complement. Products use Q1.15 scaling, and every unit saturates its result instead of wrapping.

A host pulses `start_i` with a mode code, six variable operands on `var_i` and four constants on `coef_i`. On that edge the operands go into an input register file and the constants into a constant register. The first interconnect stage receives both on the next cycle. Units that the chosen mode does not need receive no enable. The result lands in an output register file together with a one-cycle `valid_o` pulse. Only one operation is in flight at a time. The unused code raises a one-cycle error flag and starts nothing.

Top module: `recfg_pe`

## Requirements
- R1: Mode 000 sets lane 0 of `result_o` to sat(x0 + x1). Mode 010 sets it to sat(x0 − x1). Here xk is bits [16k+15:16k] of `var_i` and sat clamps to [−32768, 32767].
- R2: Mode 001 sets lane 0 to sat((x0·c0) >>> 15). Here ck is bits [16k+15:16k] of `coef_i`.
- R3: Mode 011 computes a butterfly with a=x0, b=x1, c=x2, d=x3, m=c0, n=c1. It defines re = sat(qm(c,m) − qm(d,n)) and im = sat(qm(d,m) + qm(c,n)), where qm is the saturated Q1.15 product. The lanes are: lane 0 = sat(a+re), lane 1 = sat(b+im), lane 2 = sat(a−re), lane 3 = sat(b−im).
- R4: Mode 100 sets lane 0 to sat(qm(x0,c1) + qm(x1,c0)).
- R5: Mode 101 sets lane 0 to sat(sat(qm(x0,c3)+qm(x1,c2)) + sat(qm(x2,c1)+qm(x3,c0))).
- R6: Mode 110 gives the R5 result on lane 0 and sat(x4 + x5) on lane 1, both in the same valid cycle.
- R7: `valid_o` is a one-cycle pulse. Counting rising edges after the edge that samples `start_i`, it is high after edge 8 for modes 000/001/010, after edge 15 for mode 100, and after edge 22 for modes 011/101/110. Each unit has 7 pipeline stages.
- R8: `busy_o` is high from the accepted start until the `valid_o` pulse. During that time `start_i`, `mode_i`, `var_i` and `coef_i` have no effect on the result, its timing or the count of valid pulses.
- R9: Mode 111 raises `err_o` for exactly the cycle after the start edge. It leaves `busy_o` low, produces no `valid_o` pulse and leaves `result_o` unchanged.
- R10: Every multiply, add and subtract saturates: a positive overflow gives 32767 and a negative overflow gives −32768, at intermediate stages as well as at the output.
- R11: Only the units a mode needs are enabled. Result lanes that a mode does not produce read 0 after its valid pulse.
- R12: While `rst_ni` is low, `valid_o`, `busy_o` and `err_o` are 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches one operation when idle |
| mode_i | input | 3 | Operation code, sampled with start |
| var_i | input | 96 | Six signed 16-bit variable operands |
| coef_i | input | 64 | Four signed Q1.15 constants |
| result_o | output | 64 | Four signed 16-bit result lanes |
| valid_o | output | 1 | One-cycle result-ready pulse |
| busy_o | output | 1 | Operation in flight |
| err_o | output | 1 | One-cycle pulse for the unused mode code |

## Verification
The hardest condition to reach from the ports is saturation inside the butterfly. There, the twiddle product difference must clamp first and then clamp again in the final add. Operands near −32768 and 32767 are chosen so that both stages overflow in one run. A second hard case is a start pulse, with different mode and data, that arrives while a 4-tap operation is mid-pipeline. The bench drives it a few cycles after launch and then confirms that the original result, its exact latency and a single valid pulse survive. The unused code is exercised right after a completed operation, so the output register holds known non-zero values that must stay intact.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int N_MUL  = 4;
  localparam int N_AS   = 7;
  localparam int N_VAR  = 6;
  localparam int N_COEF = 4;
  localparam int N_RES  = 4;

  typedef enum logic [2:0] {
    MD_ADD   = 3'd0,
    MD_MUL   = 3'd1,
    MD_SUB   = 3'd2,
    MD_BFLY  = 3'd3,
    MD_FIR2  = 3'd4,
    MD_FIR4  = 3'd5,
    MD_FIR4A = 3'd6,
    MD_NONE  = 3'd7
  } pe_mode_e;
endpackage

// File: rtl/pe_delay_line.sv
module pe_delay_line #(
  parameter int W      = 16,
  parameter int STAGES = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  logic [STAGES-1:0] vld_q;
  logic [W-1:0]      dat_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < STAGES; i++) dat_q[i] <= '0;
    end else begin
      vld_q    <= {vld_q[STAGES-2:0], vld_i};
      dat_q[0] <= vld_i ? dat_i : '0;  // idle unit shifts zeros
      for (int i = 1; i < STAGES; i++) dat_q[i] <= dat_q[i-1];
    end
  end

  assign vld_o = vld_q[STAGES-1];
  assign dat_o = dat_q[STAGES-1];

  // R8: one operation in flight -> at most one token per unit
  a_r8_one_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vld_q));
endmodule

// File: rtl/pe_mul_unit.sv
module pe_mul_unit #(
  parameter int W      = 16,
  parameter int STAGES = 7,
  parameter int FRAC   = W - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic                vld_o,
  output logic signed [W-1:0] y_o
);
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic signed [2*W-1:0] prod, shf;
  logic                  fits;
  logic [W-1:0]          res, dly;

  always_comb begin
    prod = a_i * b_i;
    shf  = prod >>> FRAC;
    fits = (&shf[2*W-1:W-1]) | ~(|shf[2*W-1:W-1]);
    res  = fits ? shf[W-1:0] : (shf[2*W-1] ? MIN_V : MAX_V);
  end

  pe_delay_line #(.W(W), .STAGES(STAGES)) u_pipe (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .vld_i (en_i),  .dat_i (res),
    .vld_o (vld_o), .dat_o (dly)
  );

  assign y_o = dly;
endmodule

// File: rtl/pe_addsub_unit.sv
module pe_addsub_unit #(
  parameter int W      = 16,
  parameter int STAGES = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                sub_i,
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic                vld_o,
  output logic signed [W-1:0] y_o
);
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] sum;
  logic [W-1:0]      res, dly;

  always_comb begin
    sum = sub_i ? ({a_i[W-1], a_i} - {b_i[W-1], b_i})
                : ({a_i[W-1], a_i} + {b_i[W-1], b_i});
    res = (sum[W] == sum[W-1]) ? sum[W-1:0] : (sum[W] ? MIN_V : MAX_V);
  end

  pe_delay_line #(.W(W), .STAGES(STAGES)) u_pipe (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .vld_i (en_i),  .dat_i (res),
    .vld_o (vld_o), .dat_o (dly)
  );

  assign y_o = dly;
endmodule

// File: rtl/recfg_pe.sv
module recfg_pe
  import pe_pkg::*;
#(
  parameter int W      = 16,
  parameter int STAGES = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [2:0]            mode_i,
  input  logic [N_VAR*W-1:0]    var_i,
  input  logic [N_COEF*W-1:0]   coef_i,
  output logic [N_RES*W-1:0]    result_o,
  output logic                  valid_o,
  output logic                  busy_o,
  output logic                  err_o
);
  // control state
  logic                busy_q, launch_q, valid_q, err_q;
  pe_mode_e            mode_q;
  logic [N_VAR*W-1:0]  rf_var_q;
  logic [N_COEF*W-1:0] rf_coef_q;
  logic [N_RES*W-1:0]  res_q, lanes;
  logic                accept, done;

  logic signed [W-1:0] x [N_VAR];
  logic signed [W-1:0] c [N_COEF];

  // unit ports
  logic signed [W-1:0] mul_a [N_MUL];
  logic signed [W-1:0] mul_b [N_MUL];
  logic signed [W-1:0] mul_y [N_MUL];
  logic [N_MUL-1:0]    mul_en, mul_vld;
  logic signed [W-1:0] as_a [N_AS];
  logic signed [W-1:0] as_b [N_AS];
  logic signed [W-1:0] as_y [N_AS];
  logic [N_AS-1:0]     as_en, as_sub, as_vld;

  always_comb begin
    for (int i = 0; i < N_VAR; i++)  x[i] = rf_var_q[i*W +: W];
    for (int i = 0; i < N_COEF; i++) c[i] = rf_coef_q[i*W +: W];
  end

  // ICN0: register files -> multipliers
  always_comb begin
    mul_en = '0;
    for (int i = 0; i < N_MUL; i++) begin
      mul_a[i] = '0;
      mul_b[i] = '0;
    end
    case (mode_q)
      MD_MUL: begin
        mul_en[0] = launch_q;
        mul_a[0]  = x[0]; mul_b[0] = c[0];
      end
      MD_BFLY: begin
        mul_en   = {N_MUL{launch_q}};
        mul_a[0] = x[2]; mul_b[0] = c[0];
        mul_a[1] = x[3]; mul_b[1] = c[1];
        mul_a[2] = x[3]; mul_b[2] = c[0];
        mul_a[3] = x[2]; mul_b[3] = c[1];
      end
      MD_FIR2: begin
        mul_en[1:0] = {2{launch_q}};
        mul_a[0] = x[0]; mul_b[0] = c[1];
        mul_a[1] = x[1]; mul_b[1] = c[0];
      end
      MD_FIR4, MD_FIR4A: begin
        mul_en = {N_MUL{launch_q}};
        for (int i = 0; i < N_MUL; i++) begin
          mul_a[i] = x[i];
          mul_b[i] = c[N_COEF-1-i];
        end
      end
      default: ;
    endcase
  end

  // ICN1..ICN3: products, register-file bypass and partial sums -> adders
  always_comb begin
    as_en  = '0;
    as_sub = '0;
    for (int i = 0; i < N_AS; i++) begin
      as_a[i] = '0;
      as_b[i] = '0;
    end
    case (mode_q)
      MD_ADD, MD_SUB: begin
        as_en[2]  = launch_q;
        as_sub[2] = (mode_q == MD_SUB);
        as_a[2]   = x[0]; as_b[2] = x[1];
      end
      MD_BFLY: begin
        as_en[0] = mul_vld[0]; as_sub[0] = 1'b1;
        as_a[0]  = mul_y[0];   as_b[0]   = mul_y[1];
        as_en[1] = mul_vld[2];
        as_a[1]  = mul_y[2];   as_b[1]   = mul_y[3];
        as_en[5:2] = {4{as_vld[0]}};
        as_a[2] = x[0]; as_b[2] = as_y[0];
        as_a[3] = x[1]; as_b[3] = as_y[1];
        as_a[4] = x[0]; as_b[4] = as_y[0]; as_sub[4] = 1'b1;
        as_a[5] = x[1]; as_b[5] = as_y[1]; as_sub[5] = 1'b1;
      end
      MD_FIR2: begin
        as_en[0] = mul_vld[0];
        as_a[0]  = mul_y[0]; as_b[0] = mul_y[1];
      end
      MD_FIR4, MD_FIR4A: begin
        as_en[0] = mul_vld[0];
        as_a[0]  = mul_y[0]; as_b[0] = mul_y[1];
        as_en[1] = mul_vld[2];
        as_a[1]  = mul_y[2]; as_b[1] = mul_y[3];
        as_en[6] = as_vld[0];
        as_a[6]  = as_y[0];  as_b[6] = as_y[1];
        if (mode_q == MD_FIR4A) begin
          // side addition timed to land with the tree result
          as_en[3] = as_vld[0];
          as_a[3]  = x[4]; as_b[3] = x[5];
        end
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < N_MUL; g++) begin : g_mul
    pe_mul_unit #(.W(W), .STAGES(STAGES), .FRAC(W-1)) u_mul (
      .clk_i (clk_i), .rst_ni(rst_ni), .en_i(mul_en[g]),
      .a_i   (mul_a[g]), .b_i(mul_b[g]),
      .vld_o (mul_vld[g]), .y_o(mul_y[g])
    );
  end

  for (genvar g = 0; g < N_AS; g++) begin : g_as
    pe_addsub_unit #(.W(W), .STAGES(STAGES)) u_as (
      .clk_i (clk_i), .rst_ni(rst_ni), .en_i(as_en[g]), .sub_i(as_sub[g]),
      .a_i   (as_a[g]), .b_i(as_b[g]),
      .vld_o (as_vld[g]), .y_o(as_y[g])
    );
  end

  // output collection
  always_comb begin
    done  = 1'b0;
    lanes = '0;
    case (mode_q)
      MD_ADD, MD_SUB: begin done = as_vld[2]; lanes[0 +: W] = as_y[2]; end
      MD_MUL:         begin done = mul_vld[0]; lanes[0 +: W] = mul_y[0]; end
      MD_BFLY: begin
        done  = as_vld[2];
        lanes = {as_y[5], as_y[4], as_y[3], as_y[2]};
      end
      MD_FIR2:        begin done = as_vld[0]; lanes[0 +: W] = as_y[0]; end
      MD_FIR4:        begin done = as_vld[6]; lanes[0 +: W] = as_y[6]; end
      MD_FIR4A: begin
        done = as_vld[6];
        lanes[0 +: W] = as_y[6];
        lanes[W +: W] = as_y[3];
      end
      default: ;
    endcase
    done = done & busy_q;
  end

  assign accept = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      launch_q  <= 1'b0;
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
      mode_q    <= MD_ADD;
      rf_var_q  <= '0;
      rf_coef_q <= '0;
      res_q     <= '0;
    end else begin
      launch_q <= accept & (mode_i != MD_NONE);
      err_q    <= accept & (mode_i == MD_NONE);
      valid_q  <= done;
      if (accept && mode_i != MD_NONE) begin
        busy_q    <= 1'b1;
        mode_q    <= pe_mode_e'(mode_i);
        rf_var_q  <= var_i;
        rf_coef_q <= coef_i;
      end else if (done) begin
        busy_q <= 1'b0;
      end
      if (done) res_q <= lanes;
    end
  end

  assign result_o = res_q;
  assign valid_o  = valid_q;
  assign busy_o   = busy_q;
  assign err_o    = err_q;

  // R7: valid is a single-cycle pulse
  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8: captured mode holds while an operation is in flight
  a_r8_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mode_q));

  // R9: error pulse never overlaps an operation
  a_r9_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !valid_o);

  // R11: bypass modes leave multipliers and first adder rank idle
  a_r11_bypass_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (mode_q == MD_ADD || mode_q == MD_SUB)
      |-> mul_vld == '0 && as_vld[1:0] == '0);

  // R11: single multiply leaves every adder idle
  a_r11_mul_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && mode_q == MD_MUL |-> as_vld == '0);
endmodule

// File: tb/recfg_pe_tb_top.sv
`timescale 1ns/1ps
module recfg_pe_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [2:0]  mode_i;
  logic [95:0] var_i;
  logic [63:0] coef_i;
  logic [63:0] result_o;
  logic        valid_o, busy_o, err_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  fin   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  recfg_pe dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .var_i(var_i), .coef_i(coef_i), .result_o(result_o),
    .valid_o(valid_o), .busy_o(busy_o), .err_o(err_o)
  );

  function automatic int satv(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int qm(input int a, input int b);
    return satv((a * b) >>> 15);
  endfunction

  function automatic int lat(input int md);
    if (md <= 2) return 8;
    if (md == 4) return 15;
    return 22;
  endfunction

  function automatic void model(input int md, input int x[6], input int c[4],
                                output int e[4]);
    int re, im, s01, s23;
    e = '{0, 0, 0, 0};
    case (md)
      0: e[0] = satv(x[0] + x[1]);
      2: e[0] = satv(x[0] - x[1]);
      1: e[0] = qm(x[0], c[0]);
      3: begin
        re = satv(qm(x[2], c[0]) - qm(x[3], c[1]));
        im = satv(qm(x[3], c[0]) + qm(x[2], c[1]));
        e[0] = satv(x[0] + re); e[1] = satv(x[1] + im);
        e[2] = satv(x[0] - re); e[3] = satv(x[1] - im);
      end
      4: e[0] = satv(qm(x[0], c[1]) + qm(x[1], c[0]));
      5, 6: begin
        s01 = satv(qm(x[0], c[3]) + qm(x[1], c[2]));
        s23 = satv(qm(x[2], c[1]) + qm(x[3], c[0]));
        e[0] = satv(s01 + s23);
        if (md == 6) e[1] = satv(x[4] + x[5]);
      end
      default: ;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lane(input int j);
    return int'($signed(result_o[j*16 +: 16]));
  endfunction

  task automatic drive(input int md, input int x[6], input int c[4]);
    mode_i = md[2:0];
    for (int k = 0; k < 6; k++) var_i[k*16 +: 16]  = x[k][15:0];
    for (int k = 0; k < 4; k++) coef_i[k*16 +: 16] = c[k][15:0];
  endtask

  // launch one op, wait for valid, check latency, lanes and pulse width
  task automatic run_op(input int md, input int x[6], input int c[4], input string req);
    int e[4];
    int k;
    model(md, x, c, e);
    @(negedge clk_i);
    drive(md, x, c);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    k = 0;
    check(busy_o == 1'b1, "R8 busy after start", int'(busy_o), 1);
    while (!valid_o && k < 40) begin
      @(negedge clk_i);
      k++;
    end
    check(k == lat(md), "R7 latency", k, lat(md));
    for (int j = 0; j < 4; j++) begin
      if (e[j] == 0 && !(md == 3 || (md == 6 && j == 1)) && j > 0)
        check(lane(j) == 0, "R11 unused lane", lane(j), 0);
      else
        check(lane(j) == e[j], req, lane(j), e[j]);
    end
    check(busy_o == 1'b0, "R8 busy clears", int'(busy_o), 0);
    @(negedge clk_i);
    check(valid_o == 1'b0, "R7 single pulse", int'(valid_o), 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; start_i = 1'b0; mode_i = '0; var_i = '0; coef_i = '0;
    repeat (3) @(negedge clk_i);
    check(valid_o == 0 && busy_o == 0 && err_o == 0, "R12 flags in reset",
          int'({valid_o, busy_o, err_o}), 0);
    check(result_o == '0, "R12 result in reset", lane(0), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_add_sub();
    run_op(0, '{1200, -345, 0, 0, 0, 0}, '{0, 0, 0, 0}, "R1 add");
    run_op(2, '{-500, 2500, 0, 0, 0, 0}, '{0, 0, 0, 0}, "R1 sub");
    run_op(0, '{30000, 5000, 0, 0, 0, 0}, '{0, 0, 0, 0}, "R10 add positive clamp");
    run_op(2, '{-30000, 5000, 0, 0, 0, 0}, '{0, 0, 0, 0}, "R10 sub negative clamp");
  endtask

  task automatic t_mul();
    run_op(1, '{16384, 0, 0, 0, 0, 0}, '{-8192, 0, 0, 0}, "R2 multiply");
    run_op(1, '{-32768, 0, 0, 0, 0, 0}, '{-32768, 0, 0, 0}, "R10 product clamp");
  endtask

  task automatic t_bfly();
    run_op(3, '{1000, -2000, 12000, -7000, 0, 0}, '{23170, -23170, 0, 0}, "R3 butterfly");
    run_op(3, '{20000, -20000, -32768, 32767, 0, 0}, '{-32768, -32768, 0, 0},
           "R10 butterfly inner clamp");
  endtask

  task automatic t_fir();
    run_op(4, '{8000, -4000, 0, 0, 0, 0}, '{16384, 8192, 0, 0}, "R4 two-tap");
    run_op(5, '{1000, 2000, -3000, 4000, 0, 0}, '{8192, -16384, 24576, 4096}, "R5 four-tap");
    run_op(6, '{-1000, 7000, 300, -20000, 1234, -4321}, '{3000, 9000, -12000, 30000},
           "R6 four-tap with side add");
  endtask

  task automatic t_busy_ignore();
    int x[6] = '{3000, -3000, 6000, 9000, 0, 0};
    int c[4] = '{1000, 2000, 3000, 4000};
    int e[4];
    int k, pulses;
    model(5, x, c, e);
    @(negedge clk_i);
    drive(5, x, c);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    k = 0;
    while (!valid_o && k < 40) begin
      @(negedge clk_i);
      k++;
      if (k == 3) begin
        drive(0, '{111, 222, 333, 444, 555, 666}, '{7, 7, 7, 7});
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    check(k == 22, "R8 latency with stray start", k, 22);
    check(lane(0) == e[0], "R8 result with stray start", lane(0), e[0]);
    pulses = 0;
    repeat (30) begin
      @(negedge clk_i);
      if (valid_o) pulses++;
    end
    check(pulses == 0, "R8 no extra pulse", pulses, 0);
  endtask

  task automatic t_bad_mode();
    logic [63:0] held;
    int pulses;
    held = result_o;
    @(negedge clk_i);
    drive(7, '{5, 5, 5, 5, 5, 5}, '{5, 5, 5, 5});
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(err_o == 1'b1, "R9 error raised", int'(err_o), 1);
    check(busy_o == 1'b0, "R9 stays idle", int'(busy_o), 0);
    @(negedge clk_i);
    check(err_o == 1'b0, "R9 error one cycle", int'(err_o), 0);
    pulses = 0;
    repeat (30) begin
      @(negedge clk_i);
      if (valid_o) pulses++;
    end
    check(pulses == 0, "R9 no valid", pulses, 0);
    check(result_o == held, "R9 result held", lane(0), int'($signed(held[15:0])));
  endtask

  initial begin
    #(100000 * 5);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add_sub();
    t_mul();
    t_bfly();
    t_fir();
    t_busy_ignore();
    t_bad_mode();
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule